// File: doc/BRIEF.md
# Ordering Table Clear DMA

This engine fills a region of memory with an empty, backward-linked list of 32-bit entries, the kind of list a display pipeline uses to bucket primitives by depth. Software loads a start address and an entry count, then writes a control word with bit 24 set. If the control word is exactly `0x11000002`, the engine writes one word per entry. It starts at the programmed address and steps down by 4 bytes each time. Each word points at the entry just below it, and the lowest entry holds an end marker in place of a pointer.

Memory writes go out one at a time over a request/grant word bus. When the run ends, the engine clears control bit 24 (busy) and pulses a completion interrupt. A control word with bit 24 set but any other value ends at once: it makes no writes, and it still clears busy and raises the interrupt. Registers are selected by `reg_sel`: 0 is the start address, 1 is the entry count, 2 is the control word, and 3 reads as zero.

The sequencer has four states:
- IDLE waits for busy and loads the address walker (IDLE→CHECK).
- CHECK decides between filling (CHECK→WRITE) and finishing at once (CHECK→DONE). It finishes at once on a wrong control word or a zero count.
- WRITE holds a request until it is granted. It stays in WRITE while entries remain and goes to DONE after the last grant.
- DONE pulses the interrupt and clears busy (DONE→IDLE).

Top module: `otc_dma`

## Requirements
- R1: After reset, `busy`, `irq` and `mem_req` are low, and every register reads as zero.
- R2: A control write with bit 24 set while idle starts a run, and `busy` then reads high. `busy` always equals control bit 24, readable at `reg_sel`=2. A control write with bit 24 clear only stores the value.
- R3: Memory writes happen only when the control word equals exactly `0x11000002`. Any other started control word makes no writes.
- R4: The number of granted writes equals the entry count. A count of 0 makes no writes.
- R5: Write i (counting from 0) goes to the start address minus 4·i, modulo 2^ADDR_W.
- R6: Every entry except the last holds its own address minus 4, masked to 24 bits, with bits 31:24 zero.
- R7: The last entry, at the lowest address, holds `0x00FFFFFF`. A count of 1 writes only this marker, at the start address.
- R8: Every started run ends with exactly one single-cycle `irq` pulse. `busy` is low in the cycle after the pulse, and the control word keeps all its other bits.
- R9: At most one request is outstanding. `mem_req` stays high with `mem_addr` and `mem_wdata` stable until `mem_gnt`, and the address moves down by 4 only after a grant.
- R10: Register writes while busy are ignored. All three registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 address, 1 count, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory write request |
| mem_gnt | input | 1 | Memory write grant |
| mem_addr | output | ADDR_W | Byte address of the word being written |
| mem_wdata | output | 32 | Word being written |
| busy | output | 1 | Run in progress (control bit 24) |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Two cases are the hardest to reach from the ports: register writes landing while a run is in flight, and a request held for a long time. The bench forces both by freezing the grant line partway through a run. While the grant is held off, it writes all three registers and watches the pending request, then releases the grant. Grants are otherwise random, so back-to-back and delayed grants mix. Directed runs cover a zero count, a single entry, a bad control word and an address walk that wraps past zero.

// File: rtl/otc_pkg.sv
package otc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WRITE,
        ST_DONE
    } otc_state_t;

    localparam logic [31:0] FILL_CMD = 32'h1100_0002;
    localparam int          BUSY_BIT = 24;
    localparam int          PTR_W    = 24;
    localparam logic [PTR_W-1:0] END_MARK = '1;
endpackage

// File: rtl/otc_regs.sv
module otc_regs #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [31:0]       wdata,
    input  logic              done,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  entry_cnt,
    output logic [31:0]       ctrl_word,
    output logic [31:0]       rdata
);
    import otc_pkg::*;

    logic wr_ok;
    assign wr_ok = we && !ctrl_word[BUSY_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            entry_cnt <= '0;
            ctrl_word <= '0;
        end else begin
            if (done)
                ctrl_word[BUSY_BIT] <= 1'b0;
            if (wr_ok) begin
                unique case (sel)
                    2'd0:    base_addr <= wdata[ADDR_W-1:0];
                    2'd1:    entry_cnt <= wdata[CNT_W-1:0];
                    2'd2:    ctrl_word <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel)
            2'd0:    rdata = 32'(base_addr);
            2'd1:    rdata = 32'(entry_cnt);
            2'd2:    rdata = ctrl_word;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/otc_walker.sv
module otc_walker #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  entry_cnt,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [31:0]       word,
    output logic              last,
    output logic              empty
);
    import otc_pkg::*;

    logic [CNT_W-1:0]  left;
    logic [ADDR_W-1:0] below;
    logic [PTR_W-1:0]  ptr;

    assign below = cur_addr - ADDR_W'(4);
    assign ptr   = PTR_W'(below);
    assign last  = (left == CNT_W'(1));
    assign empty = (left == '0);
    assign word  = last ? 32'(END_MARK) : 32'(ptr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            left     <= '0;
        end else if (load) begin
            cur_addr <= base_addr;
            left     <= entry_cnt;
        end else if (step) begin
            cur_addr <= below;
            left     <= left - CNT_W'(1);
        end
    end
endmodule

// File: rtl/otc_fsm.sv
module otc_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic cmd_ok,
    input  logic empty,
    input  logic last,
    input  logic gnt,
    output logic load,
    output logic step,
    output logic req,
    output logic done,
    output logic irq
);
    import otc_pkg::*;

    otc_state_t state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (busy) nxt = ST_CHECK;
            ST_CHECK: nxt = (cmd_ok && !empty) ? ST_WRITE : ST_DONE;
            ST_WRITE: if (gnt && last) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load = (state == ST_IDLE) && busy;
        req  = (state == ST_WRITE);
        step = (state == ST_WRITE) && gnt;
        done = (state == ST_DONE);
        irq  = (state == ST_DONE);
    end
endmodule

// File: rtl/otc_dma.sv
module otc_dma #(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    input  logic              mem_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic              busy,
    output logic              irq
);
    import otc_pkg::*;

    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  entry_cnt;
    logic [31:0]       ctrl_word;
    logic              load, step, done, last, empty, cmd_ok;

    assign busy   = ctrl_word[BUSY_BIT];
    assign cmd_ok = (ctrl_word == FILL_CMD);

    otc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel),
        .wdata(reg_wdata), .done(done), .base_addr(base_addr),
        .entry_cnt(entry_cnt), .ctrl_word(ctrl_word), .rdata(reg_rdata)
    );

    otc_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .base_addr(base_addr), .entry_cnt(entry_cnt),
        .cur_addr(mem_addr), .word(mem_wdata), .last(last), .empty(empty)
    );

    otc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_ok(cmd_ok),
        .empty(empty), .last(last), .gnt(mem_gnt), .load(load),
        .step(step), .req(mem_req), .done(done), .irq(irq)
    );
endmodule

// File: rtl/otc_dma_chk.sv
module otc_dma_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              busy,
    input logic              irq
);
    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_wdata));

    // R5
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_gnt |=> !mem_req || (mem_addr == $past(mem_addr) - ADDR_W'(4)));

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_wdata[31:24] == 8'h00);

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq && !busy);

    // R2
    req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !irq);
endmodule

bind otc_dma otc_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .irq(irq)
);

// File: tb/otc_dma_test.sv
module otc_dma_test;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 16;
    localparam logic [31:0] CMD = 32'h1100_0002;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we = 1'b0;
    logic [1:0]        reg_sel = 2'd0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              mem_req;
    logic              mem_gnt = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              busy, irq;

    int checks = 0;
    int fails  = 0;
    int nwr = 0;
    int nirq = 0;
    int cyc = 0;
    bit gnt_hold = 1'b0;
    bit gnt_all  = 1'b0;
    logic [ADDR_W-1:0] log_addr [0:255];
    logic [31:0]       log_data [0:255];
    int w0, i0;

    always #5 clk = ~clk;

    otc_dma #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_gnt(mem_gnt), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .irq(irq)
    );

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_gnt) begin
            log_addr[nwr % 256] <= mem_addr;
            log_data[nwr % 256] <= mem_wdata;
            nwr <= nwr + 1;
        end
        if (rst_n && irq) nirq <= nirq + 1;
    end

    always @(negedge clk) begin
        if (gnt_hold)     mem_gnt <= 1'b0;
        else if (gnt_all) mem_gnt <= 1'b1;
        else              mem_gnt <= ($urandom % 3) != 0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] sa, input int i);
        return sa - ADDR_W'(4 * i);
    endfunction

    function automatic logic [31:0] exp_word(input logic [ADDR_W-1:0] sa, input int i, input int cnt);
        logic [ADDR_W-1:0] a;
        a = exp_addr(sa, i) - ADDR_W'(4);
        if (i == cnt - 1) return 32'h00FF_FFFF;
        return {8'h00, a[23:0]};
    endfunction

    task automatic start_run(input logic [ADDR_W-1:0] sa, input int cnt, input logic [31:0] cw);
        w0 = nwr; i0 = nirq;
        reg_write(2'd0, 32'(sa));
        reg_write(2'd1, 32'(cnt));
        reg_write(2'd2, cw);
        // R2: busy follows control bit 24 right after the write
        chk(busy === 1'b1, "R2 busy after start", 32'(busy), 32'd1);
    endtask

    task automatic finish_run(input logic [ADDR_W-1:0] sa, input int cnt, input logic [31:0] cw);
        int t = 0;
        int n;
        logic [31:0] rd;
        while (busy && t < 5000) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        n = (cw == CMD) ? cnt : 0;
        // R8: one irq and busy cleared, other bits kept
        chk(nirq - i0 == 1, "R8 irq count", 32'(nirq - i0), 32'd1);
        chk(busy === 1'b0, "R8 busy cleared", 32'(busy), 32'd0);
        reg_read(2'd2, rd);
        chk(rd == (cw & ~32'h0100_0000), "R8 control readback", rd, cw & ~32'h0100_0000);
        // R3 R4: write count
        chk(nwr - w0 == n, (cw == CMD) ? "R4 write count" : "R3 no writes on other control",
            32'(nwr - w0), 32'(n));
        if (nwr - w0 == n) begin
            for (int i = 0; i < n; i++) begin
                chk(log_addr[(w0 + i) % 256] == exp_addr(sa, i), "R5 address",
                    32'(log_addr[(w0 + i) % 256]), 32'(exp_addr(sa, i)));
                chk(log_data[(w0 + i) % 256] == exp_word(sa, i, n),
                    (i == n - 1) ? "R7 end marker" : "R6 pointer",
                    log_data[(w0 + i) % 256], exp_word(sa, i, n));
            end
        end
    endtask

    task automatic run(input logic [ADDR_W-1:0] sa, input int cnt, input logic [31:0] cw);
        start_run(sa, cnt, cw);
        finish_run(sa, cnt, cw);
    endtask

    initial begin
        logic [31:0] rd;
        logic [ADDR_W-1:0] held_a;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(busy === 1'b0 && irq === 1'b0 && mem_req === 1'b0, "R1 outputs idle",
            {29'd0, busy, irq, mem_req}, 32'd0);
        for (int s = 0; s < 4; s++) begin
            reg_read(2'(s), rd);
            chk(rd == 32'd0, "R1 register zero", rd, 32'd0);
        end

        // R2: bit 24 clear only stores
        reg_write(2'd2, 32'h1000_0002);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && nwr == 0, "R2 no start without bit 24", 32'(nwr), 32'd0);
        reg_read(2'd2, rd);
        chk(rd == 32'h1000_0002, "R2 control stored", rd, 32'h1000_0002);

        gnt_all = 1'b1;
        run(24'h00_1000, 4, CMD);        // back-to-back grants
        gnt_all = 1'b0;
        run(24'h00_2000, 0, CMD);        // R4 zero count
        run(24'h00_3000, 1, CMD);        // R7 single marker
        run(24'h00_4000, 5, 32'h0100_0201); // R3 other control
        run(24'h00_5000, 3, CMD ^ 32'h0000_0001); // R3 near miss
        run(24'h00_0004, 3, CMD);        // R5 wrap below zero

        // R10 and R9: writes while a request is held off
        gnt_hold = 1'b1;
        start_run(24'h00_8000, 3, CMD);
        repeat (2) @(negedge clk);
        held_a = mem_addr;
        reg_write(2'd0, 32'h0000_1234);
        reg_write(2'd1, 32'd9);
        reg_write(2'd2, 32'h0000_0000);
        chk(mem_req === 1'b1 && mem_addr == held_a, "R9 request held", 32'(mem_addr), 32'(held_a));
        chk(nwr == w0, "R9 no write without grant", 32'(nwr - w0), 32'd0);
        reg_read(2'd0, rd);
        chk(rd == 32'h0000_8000, "R10 address kept", rd, 32'h0000_8000);
        reg_read(2'd1, rd);
        chk(rd == 32'd3, "R10 count kept", rd, 32'd3);
        reg_read(2'd2, rd);
        chk(rd == CMD, "R10 control kept", rd, CMD);
        gnt_hold = 1'b0;
        finish_run(24'h00_8000, 3, CMD);

        for (int k = 0; k < 25; k++) begin
            logic [ADDR_W-1:0] sa;
            int cnt;
            logic [31:0] cw;
            sa  = ADDR_W'({$urandom % 24'h40_0000, 2'b00});
            cnt = int'($urandom % 21);
            cw  = (($urandom % 4) != 0) ? CMD : (CMD ^ (32'd1 << ($urandom % 24)));
            run(sa, cnt, cw);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule